// File: doc/BRIEF.md
# Local Interrupt Controller Timer

This block is the countdown timer of a processor-local interrupt controller. Software programs three things through a simple write port: a starting count, a clock divider setting, and a timer entry holding an 8-bit vector, a mask bit and a mode bit. Writing the starting count launches the timer from that very cycle. The block then counts down once per prescaled tick and presents the live value on a read-only current-count output.

There are two modes. In one-shot mode the count runs down to zero and stays there, and the block raises one interrupt request one tick after zero is reached. In periodic mode the count runs down, reloads the starting value on the tick that follows zero, and raises a request on every reload. The request is a single-cycle pulse on `irq`, and the entry's vector is driven on `irq_vector` in the same cycle. A masked entry keeps the count running but stops every request. A starting count of zero schedules nothing.

Top module: `lapic_timer`

## Requirements
- R1: After reset `cur_count` is 0 and `irq` is 0. The timer entry is masked, in one-shot mode, with vector 0. The divide setting is 0, which means divide by 2.
- R2: Register writes use `wr_sel`: 0 is the starting count, 1 is the divide setting, 2 is the timer entry, and 3 is ignored. In the divide setting, bits 3, 1 and 0 form a 3-bit value v = {bit3, bit1, bit0}. v = 7 divides by 1. Any other v divides by 2^(v+1).
- R3: Let N be the starting count, D the divider, and k the number of clock edges since the edge that took the write. In one-shot mode `cur_count` equals N − floor(k/D), and it holds at 0 once floor(k/D) reaches N.
- R4: In one-shot mode with N > 0, exactly one request is raised, visible k = (N+1)·D edges after the write. Nothing follows it.
- R5: In periodic mode with N > 0, `cur_count` equals N − (floor(k/D) mod (N+1)). A request is raised at every k that is a multiple of (N+1)·D.
- R6: The timer entry uses bits [7:0] for the vector, bit 8 for the mask (1 means masked) and bit 9 for the mode (1 means periodic). While the entry is masked, no request is raised, and the count still advances as in R3 and R5.
- R7: A starting count of 0 raises no request in either mode, and `cur_count` stays 0.
- R8: Writing a new starting count while the timer runs restarts the count and the divider phase from the cycle of that write, and the earlier schedule is dropped.
- R9: `irq` is high for exactly one cycle per expiry. While it is high, `irq_vector` carries the vector that the entry held when the expiry occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timer's undivided time base |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 starting count, 1 divide, 2 timer entry |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Live current count |
| irq | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector accompanying `irq` |

## Verification
The hardest case to reach is a restart in the middle of a countdown. The first schedule must vanish completely, and the second must be timed from the rewrite cycle rather than from a divider phase left over from the earlier run. The stimulus rewrites the count part-way through a one-shot run. It queues only the expiry that belongs to the second write, so a stray pulse from the dropped schedule arrives with no queued expectation and is reported. Periodic runs with a non-unit divider are stopped between expiries by rewriting the count to zero. This shows that the reload cadence holds across several periods and that a zero count ends the schedule.

// File: rtl/lt_pkg.sv
// Package lt_pkg
// Shared register selects, timer-entry bit positions and the divide-setting
// decode for the local interrupt controller timer.
package lt_pkg;

    typedef enum logic [1:0] {
        SEL_INIT  = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_ENTRY = 2'd2,
        SEL_NONE  = 2'd3
    } lt_sel_e;

    localparam int ENT_MASK_BIT = 8;
    localparam int ENT_PER_BIT  = 9;
    localparam int SHIFT_W      = 3;

    // Map the divide setting (bits 3,1,0) to a right-shift amount.
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] d);
        logic [2:0] v;
        v = {d[3], d[1], d[0]};
        if (v == 3'b111) return '0;
        return v + 3'd1;
    endfunction

endpackage

// File: rtl/lt_regs.sv
// Module lt_regs
// Holds the programmable state: starting count, divide shift and timer entry.
// Assumes at most one write per cycle; a write to select 3 is dropped.
// Produces a load strobe in the cycle the starting count is written.
module lt_regs
    import lt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [CNT_W-1:0]    wr_data,
    output logic                load,
    output logic [CNT_W-1:0]    init_q,
    output logic [SHIFT_W-1:0]  shift_q,
    output logic                mask_q,
    output logic                periodic_q,
    output logic [VEC_W-1:0]    vec_q
);

    lt_sel_e sel;

    // Decode the select into the register enum.
    always_comb sel = lt_sel_e'(wr_sel);

    // Strobe that restarts the timer.
    always_comb load = wr_en && (sel == SEL_INIT);

    // Register updates with reset to masked, one-shot, divide-by-2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q     <= '0;
            shift_q    <= div_to_shift(4'h0);
            mask_q     <= 1'b1;
            periodic_q <= 1'b0;
            vec_q      <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_INIT:  init_q  <= wr_data;
                SEL_DIV:   shift_q <= div_to_shift(wr_data[3:0]);
                SEL_ENTRY: begin
                    vec_q      <= wr_data[VEC_W-1:0];
                    mask_q     <= wr_data[ENT_MASK_BIT];
                    periodic_q <= wr_data[ENT_PER_BIT];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lt_prescaler.sv
// Module lt_prescaler
// Divides the clock by 2^shift into a one-cycle tick. The phase restarts on
// a starting-count write, so the first tick lands 2^shift edges later.
// A shrinking shift takes effect at once through the >= compare.
module lt_prescaler
    import lt_pkg::*;
#(
    parameter int PRE_W = (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // Terminal value of the phase counter for the current shift.
    always_comb limit = PRE_W'((32'd1 << shift) - 32'd1);

    // Tick when the phase counter reaches its terminal value.
    always_comb tick = (pre_q >= limit);

    // Phase counter: cleared on restart and on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) pre_q <= '0;
        else                           pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/lt_counter.sv
// Module lt_counter
// Down-counter that steps on each tick. In one-shot mode it saturates at
// zero and flags one expiry on the tick after zero. In periodic mode it
// reloads on that tick and flags an expiry each time. A load has priority
// over a tick in the same cycle.
module lt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    logic armed_q;
    logic at_zero;

    // Count has run out.
    always_comb at_zero = (cnt_q == '0);

    // Expiry strobe: tick at zero, with a schedule pending.
    always_comb expire = tick && !load && at_zero &&
                         (periodic ? (reload_val != '0) : armed_q);

    // Count and one-shot arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            armed_q <= (load_val != '0);
        end else if (tick) begin
            if (at_zero) begin
                armed_q <= 1'b0;
                if (periodic) cnt_q <= reload_val;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/lapic_timer.sv
// Module lapic_timer
// Timer of a processor-local interrupt controller. It joins the register
// block, the prescaler and the down-counter, and registers the expiry into
// a one-cycle request with its vector. Assumes one clock domain and a
// synchronous active-low reset.
module lapic_timer
    import lt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cur_count,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vector
);

    logic               load;
    logic [CNT_W-1:0]   init_q;
    logic [SHIFT_W-1:0] shift_q;
    logic               mask_q;
    logic               periodic_q;
    logic [VEC_W-1:0]   vec_q;
    logic               tick;
    logic               expire;

    lt_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .load       (load),
        .init_q     (init_q),
        .shift_q    (shift_q),
        .mask_q     (mask_q),
        .periodic_q (periodic_q),
        .vec_q      (vec_q)
    );

    lt_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .shift   (shift_q),
        .tick    (tick)
    );

    lt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (wr_data),
        .reload_val (init_q),
        .tick       (tick),
        .periodic   (periodic_q),
        .cnt_q      (cur_count),
        .expire     (expire)
    );

    // Register the unmasked expiry into a request pulse with its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq <= expire && !mask_q;
            if (expire) irq_vector <= vec_q;
        end
    end

endmodule

// File: rtl/lapic_timer_chk.sv
// Module lapic_timer_chk
// Temporal checks on the timer, attached to every lapic_timer instance.
module lapic_timer_chk #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] cur_count,
    input logic             irq,
    input logic [VEC_W-1:0] irq_vector,
    input logic [CNT_W-1:0] init_q,
    input logic             mask_q,
    input logic             periodic_q,
    input logic [VEC_W-1:0] vec_q
);

    // R9: request lasts one cycle
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: vector matches the entry at expiry
    a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_vector == $past(vec_q));

    // R6: no request out of a masked entry
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(mask_q));

    // R4: expiry only from an exhausted count
    a_r4_fire_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cur_count) == '0);

    // R3: one-shot count holds at zero without rewrites
    a_r3_oneshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0 && !periodic_q &&
         !(wr_en && (wr_sel == 2'd0 || wr_sel == 2'd2))) |=> cur_count == '0);

    // R5: count never exceeds the starting value
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cur_count <= init_q);

endmodule

bind lapic_timer lapic_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .cur_count  (cur_count),
    .irq        (irq),
    .irq_vector (irq_vector),
    .init_q     (init_q),
    .mask_q     (mask_q),
    .periodic_q (periodic_q),
    .vec_q      (vec_q)
);

// File: tb/lapic_timer_tb.sv
`timescale 1ns/1ps
module lapic_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] cur_count;
    logic        irq;
    logic [7:0]  irq_vector;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    int       exp_t[$];
    bit [7:0] exp_v[$];
    bit       prev_irq = 1'b0;

    lapic_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cur_count(cur_count), .irq(irq),
        .irq_vector(irq_vector)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: one register write; returns the edge count after the write edge.
    task automatic wr(input logic [1:0] sel, input logic [31:0] d, output int t);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        t = cyc;
    endtask

    task automatic expect_irq(input int t, input bit [7:0] v);
        exp_t.push_back(t);
        exp_v.push_back(v);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: pop and compare every request against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq && prev_irq) chk("R9 pulse width", 32'd2, 32'd1);
            if (irq) begin
                if (exp_t.size() == 0) begin
                    chk("R4/R6/R7/R8 unexpected irq cycle", cyc, 32'hFFFFFFFF);
                end else begin
                    int  t;
                    bit [7:0] v;
                    t = exp_t.pop_front();
                    v = exp_v.pop_front();
                    chk("R4/R5 irq cycle", cyc, t);
                    chk("R9 irq vector", {24'd0, irq_vector}, {24'd0, v});
                end
            end
            prev_irq = irq;
        end
    end

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int t0, t1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 count after reset", cur_count, 32'd0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R3/R4: one-shot, divide by 1 (v=7 -> 0xB), N=5
        wr(2'd1, 32'hB, t0);
        wr(2'd2, 32'h041, t0);
        wr(2'd0, 32'd5, t0);
        expect_irq(t0 + 6, 8'h41);
        wait_to(t0 + 3);
        chk("R3 one-shot count at k=3", cur_count, 32'd2);
        wait_to(t0 + 30);
        chk("R3 one-shot saturates", cur_count, 32'd0);
        chk("R4 one expiry only", exp_t.size(), 32'd0);

        // R5 + R2: periodic, divide setting 0 -> divide by 2, N=3
        wr(2'd1, 32'h0, t0);
        wr(2'd2, 32'h255, t0);
        wr(2'd0, 32'd3, t0);
        expect_irq(t0 + 8, 8'h55);
        expect_irq(t0 + 16, 8'h55);
        expect_irq(t0 + 24, 8'h55);
        wait_to(t0 + 3);
        chk("R5 periodic count k=3", cur_count, 32'd2);
        wait_to(t0 + 9);
        chk("R5 periodic reload k=9", cur_count, 32'd3);
        wait_to(t0 + 26);
        wr(2'd0, 32'd0, t1);
        wait_to(t1 + 40);
        chk("R5 three periods seen", exp_t.size(), 32'd0);
        chk("R7 periodic zero holds count", cur_count, 32'd0);

        // R6: masked one-shot counts but stays quiet
        wr(2'd1, 32'hB, t0);
        wr(2'd2, 32'h177, t0);
        wr(2'd0, 32'd4, t0);
        wait_to(t0 + 2);
        chk("R6 masked count advances", cur_count, 32'd2);
        wait_to(t0 + 20);
        chk("R6 masked count reaches 0", cur_count, 32'd0);

        // R7: one-shot with zero count
        wr(2'd2, 32'h033, t0);
        wr(2'd0, 32'd0, t0);
        wait_to(t0 + 20);
        chk("R7 one-shot zero count", cur_count, 32'd0);

        // R8: restart mid-run
        wr(2'd2, 32'h022, t0);
        wr(2'd0, 32'd10, t0);
        wait_to(t0 + 4);
        chk("R8 before restart", cur_count, 32'd6);
        wr(2'd0, 32'd3, t1);
        expect_irq(t1 + 4, 8'h22);
        wait_to(t1 + 1);
        chk("R8 restarted count", cur_count, 32'd2);
        wait_to(t1 + 30);
        chk("R8 single expiry after restart", exp_t.size(), 32'd0);

        // R2: setting 0x8 -> v=4 -> divide by 32, N=1
        wr(2'd1, 32'h8, t0);
        wr(2'd2, 32'h0AA, t0);
        wr(2'd3, 32'h3FF, t1);
        wr(2'd0, 32'd1, t0);
        expect_irq(t0 + 64, 8'hAA);
        wait_to(t0 + 31);
        chk("R2 divide-by-32 before tick", cur_count, 32'd1);
        wait_to(t0 + 32);
        chk("R2 divide-by-32 after tick", cur_count, 32'd0);
        wait_to(t0 + 100);
        chk("R2 divide-by-32 expiry seen", exp_t.size(), 32'd0);

        done = 1'b1;
        report();
    end

endmodule